// File: doc/BRIEF.md
# Dual Reference Clock Activity Monitor

This block watches two reference clock inputs from the domain of a slower feedback clock and keeps one bad flag per reference. Each reference passes through a synchronizer into the feedback domain. The block looks for a change between consecutive samples. A reference that holds one level for a whole evaluation window of one feedback period has its flag set. A reference that shows a transition has its flag cleared, so each flag tracks the live health of its input rather than latching the first fault.

An active-low initialization input is also brought into the feedback domain. Its falling edge clears both flags for one feedback cycle. Evaluation resumes normally on the next cycle. An active-low asynchronous reset puts both flags to 0. Both flags are registered in the feedback domain.

Top module: `ref_activity_mon`

## Requirements
- R1: While rst_ni is low, bad_o is 0 on both bits, and it drops to 0 as soon as rst_ni falls, without waiting for a clock edge.
- R2: With default parameters, let L(k) be the level of ref_i[i] sampled at feedback rising edge k. After edge n, bad_o[i] is 1 when L(n-2) equals L(n-3), so a reference held for one full feedback period is flagged. The first edge after reset counts as n=1, and L(k) is 0 for k below 1.
- R3: Under the same numbering, bad_o[i] is 0 after edge n when L(n-2) differs from L(n-3), so a flag clears again once its reference toggles.
- R4: The two flags are independent: a stuck ref_i[0] raises only bit 0 while a toggling ref_i[1] keeps bit 1 low, and the same holds with the roles swapped.
- R5: Let I(k) be the level of init_ni sampled at edge k, with I(k)=1 for k below 1. When I(n-3) is 1 and I(n-2) is 0, both bits of bad_o are 0 after edge n, whatever the references do.
- R6: Holding init_ni low past that one cycle, or a low-to-high change on it, has no effect on the flags: R2 and R3 apply as normal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Feedback clock; all state is clocked by it |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_ni | input | 1 | Initialization request, active low; its falling edge clears the flags |
| ref_i | input | NUM_REF | Reference clocks under watch, asynchronous to clk_i |
| bad_o | output | NUM_REF | Per-reference stuck flag, 1 = no transition in the last window |

## Verification
The assertions assume ref_i and init_ni settle cleanly into the synchronizers. Under that assumption, a level seen at one feedback edge is seen at the next synchronizer stage one edge later, and the sampled history matches the driven history. The bench keeps within this by changing ref_i and init_ni only on the falling edge of clk_i, so each level is held across a full rising edge. Faster references are not modelled, because sampling them at the feedback rate could alias. The random phase draws per-cycle levels with a fixed seed and only occasionally moves init_ni. Both a fall and a held-low interval therefore appear.

// File: rtl/ref_activity_pkg.sv
package ref_activity_pkg;
  parameter int unsigned DEF_NUM_REF     = 2;
  parameter int unsigned DEF_SYNC_STAGES = 2;
  parameter int unsigned DEF_WIN_CYCLES  = 1;

  function automatic int unsigned cnt_width(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/ref_activity_sync.sv
module ref_activity_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ref_activity_edge.sv
module ref_activity_edge #(
  parameter int unsigned WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] q_i,
  output logic [WIDTH-1:0] chg_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= q_i;
  end

  assign chg_o = q_i ^ prev_q;
endmodule

// File: rtl/ref_activity_window.sv
module ref_activity_window #(
  parameter int unsigned WIN_CYCLES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic win_end_o
);
  localparam int unsigned CW = ref_activity_pkg::cnt_width(WIN_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign win_end_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (restart_i || win_end_o) cnt_q <= '0;
    else                             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ref_activity_flag.sv
module ref_activity_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic win_end_i,
  input  logic chg_i,
  output logic bad_o
);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      bad_o  <= 1'b0;
    end else if (clr_i) begin
      seen_q <= 1'b0;
      bad_o  <= 1'b0;
    end else if (win_end_i) begin
      bad_o  <= ~(seen_q | chg_i);
      seen_q <= 1'b0;
    end else if (chg_i) begin
      seen_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ref_activity_mon.sv
module ref_activity_mon #(
  parameter int unsigned NUM_REF     = ref_activity_pkg::DEF_NUM_REF,
  parameter int unsigned SYNC_STAGES = ref_activity_pkg::DEF_SYNC_STAGES,
  parameter int unsigned WIN_CYCLES  = ref_activity_pkg::DEF_WIN_CYCLES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               init_ni,
  input  logic [NUM_REF-1:0] ref_i,
  output logic [NUM_REF-1:0] bad_o
);
  logic [NUM_REF-1:0] ref_sync;
  logic [NUM_REF-1:0] ref_chg;
  logic               init_sync;
  logic               init_chg;
  logic               init_fall;
  logic               win_end;

  ref_activity_sync #(.WIDTH(NUM_REF), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_ref_sync (
    .clk_i, .rst_ni, .d_i(ref_i), .q_o(ref_sync)
  );

  ref_activity_edge #(.WIDTH(NUM_REF), .RST_VAL('0)) i_ref_edge (
    .clk_i, .rst_ni, .q_i(ref_sync), .chg_o(ref_chg)
  );

  // init idles high, so reset values of 1 avoid a false fall
  ref_activity_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_init_sync (
    .clk_i, .rst_ni, .d_i(init_ni), .q_o(init_sync)
  );

  ref_activity_edge #(.WIDTH(1), .RST_VAL(1'b1)) i_init_edge (
    .clk_i, .rst_ni, .q_i(init_sync), .chg_o(init_chg)
  );

  assign init_fall = init_chg & ~init_sync;

  ref_activity_window #(.WIN_CYCLES(WIN_CYCLES)) i_window (
    .clk_i, .rst_ni, .restart_i(init_fall), .win_end_o(win_end)
  );

  for (genvar i = 0; i < NUM_REF; i++) begin : g_flag
    ref_activity_flag i_flag (
      .clk_i,
      .rst_ni,
      .clr_i    (init_fall),
      .win_end_i(win_end),
      .chg_i    (ref_chg[i]),
      .bad_o    (bad_o[i])
    );
  end
endmodule

// File: rtl/ref_activity_mon_chk.sv
module ref_activity_mon_chk #(
  parameter int unsigned NUM_REF = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_REF-1:0] bad_o,
  input logic [NUM_REF-1:0] ref_chg,
  input logic               init_fall,
  input logic               win_end
);
  logic [NUM_REF-1:0] seen_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    seen_c <= '0;
    else if (init_fall || win_end)  seen_c <= '0;
    else                            seen_c <= seen_c | ref_chg;
  end

  always @(negedge clk_i) begin
    if (!rst_ni) assert_rst_R1: assert (bad_o == '0);
  end

  assert_init_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_fall |=> (bad_o == '0));

  for (genvar i = 0; i < NUM_REF; i++) begin : g_ch
    assert_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (win_end && !init_fall && !ref_chg[i] && !seen_c[i]) |=> bad_o[i]);

    assert_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (win_end && !init_fall && ref_chg[i]) |=> !bad_o[i]);

    assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!win_end && !init_fall) |=> $stable(bad_o[i]));
  end
endmodule

bind ref_activity_mon ref_activity_mon_chk #(.NUM_REF(NUM_REF)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .bad_o    (bad_o),
  .ref_chg  (ref_chg),
  .init_fall(init_fall),
  .win_end  (win_end)
);

// File: tb/test_ref_activity_mon.sv
module test_ref_activity_mon;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       init_ni = 1'b1;
  logic [1:0] ref_i = 2'b00;
  logic [1:0] bad_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  ref_activity_mon i_ref_activity_mon (
    .clk_i, .rst_ni, .init_ni, .ref_i, .bad_o
  );

  always #10 clk_i = ~clk_i;

  // sampled history, index 0 = newest edge
  logic [3:0] h0, h1, ih;
  int nedges;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h0 <= 4'b0000; h1 <= 4'b0000; ih <= 4'b1111; nedges <= 0;
    end else begin
      h0 <= {h0[2:0], ref_i[0]};
      h1 <= {h1[2:0], ref_i[1]};
      ih <= {ih[2:0], init_ni};
      nedges <= nedges + 1;
    end
  end

  function automatic logic init_fell();
    return ih[3] & ~ih[2];
  endfunction

  function automatic logic [1:0] expected();
    if (nedges == 0 || init_fell()) return 2'b00;
    return {h1[2] == h1[3], h0[2] == h0[3]};
  endfunction

  task automatic check_now(input string tag);
    logic [1:0] e;
    e = expected();
    for (int b = 0; b < 2; b++) begin
      string t;
      t = init_fell() ? "R5" : (tag != "" ? tag : (e[b] ? "R2" : "R3"));
      checks++;
      if (bad_o[b] !== e[b]) begin
        failures++;
        $display("FAIL %s bit%0d actual=%0b expected=%0b", t, b, bad_o[b], e[b]);
      end
    end
  endtask

  task automatic step(input logic [1:0] r, input logic ini, input string tag);
    @(negedge clk_i);
    check_now(tag);
    ref_i = r;
    init_ni = ini;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
    end
  end

  initial begin
    logic [1:0] cur;
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk_i);
    checks++;
    if (bad_o !== 2'b00) begin
      failures++;
      $display("FAIL R1 actual=%b expected=00", bad_o);
    end
    rst_ni = 1'b1;

    // R3: both toggle every cycle
    cur = 2'b01;
    for (int k = 0; k < 20; k++) begin cur = ~cur; step(cur, 1'b1, ""); end
    // R2: both stuck high
    for (int k = 0; k < 10; k++) step(2'b11, 1'b1, "R2");
    // R4: one stuck, other toggling, then swapped
    cur = 2'b00;
    for (int k = 0; k < 15; k++) begin cur[1] = ~cur[1]; step(cur, 1'b1, "R4"); end
    for (int k = 0; k < 15; k++) begin cur[0] = ~cur[0]; cur[1] = 1'b1; step(cur, 1'b1, "R4"); end
    // slow toggle: two cycles per level, flag alternates (R2 / R3)
    cur = 2'b00;
    for (int k = 0; k < 16; k++) begin if (k % 2 == 0) cur = ~cur; step(cur, 1'b1, ""); end
    // R5 then R6: init fall while stuck, held low, then released
    for (int k = 0; k < 6; k++) step(2'b10, 1'b1, "R2");
    for (int k = 0; k < 8; k++) step(2'b10, 1'b0, "R6");
    for (int k = 0; k < 8; k++) step(2'b10, 1'b1, "R6");
    // R1: asynchronous reset with flags raised
    @(negedge clk_i);
    #2 rst_ni = 1'b0;
    #1;
    checks++;
    if (bad_o !== 2'b00) begin
      failures++;
      $display("FAIL R1 actual=%b expected=00", bad_o);
    end
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    // random mix of levels and init activity
    cur = 2'b00;
    for (int k = 0; k < 3000; k++) begin
      logic ini;
      for (int b = 0; b < 2; b++)
        if ($urandom_range(3) != 0) cur[b] = ~cur[b];
      if ($urandom_range(7) == 0) cur = 2'b11;
      ini = init_ni;
      if ($urandom_range(15) == 0) ini = ~ini;
      step(cur, ini, "");
    end
    step(cur, 1'b1, "");
    done = 1;
    finish_run();
  end
endmodule